// File: doc/BRIEF.md
# Load-Load Ordering Violation Checker

This block keeps a small table of loads that have already received their data. For each tracked load it stores the age tag and the cache-line address. Notices that a cache line has been released mark every tracked load on that line. A load that arrives later queries the table with its own age tag, physical address, byte mask and a data-valid bit. One cycle after the query is accepted, the block answers whether a younger load to the same line read its data before that line was released. A positive answer tells the pipeline to restart execution from instruction fetch.

The query starts in the load's first pipeline stage as a ready/valid request, and the answer comes back as a valid-only response. The request is refused while a line release is presented and while the table is full. A refused load has to be reissued from the scheduler. An accepted load with valid data takes a table entry. A revoke in the following cycle cancels that entry. Entries also leave the table through an age-based retire input and a flush input. Flushing the pipeline itself and keeping the caches coherent are left to neighbouring blocks.

Top module: `lldChecker`

## Requirements
- R1: `reqReady` is 1 exactly when `releaseValid` is 0 and at least one table entry is free. After reset the table is empty and `reqReady` is 1.
- R2: `respValid` is 1 in the cycle that follows an accepted request (`reqValid && reqReady`), and 0 in every other cycle. This includes the cycle after a refused request.
- R3: `respReplay` is 1 exactly when, at the time the request was accepted, some tracked entry was released, is younger than the request, and has the same cache line. Two addresses share a line when they agree in every bit above the low `LINE_OFF_W` bits (6, giving 64-byte lines).
- R4: Age tags are `AGE_IDX_W+1` bits, and the top bit is a wrap flag. Tag A is younger than tag B when the flags are equal and A's index is greater than B's, or when the flags differ and A's index is smaller than B's. Equal tags are not younger.
- R5: An accepted request takes a table entry only when `reqDataValid` is 1 and `reqMask` is nonzero. Any other request leaves the table unchanged.
- R6: A release marks every entry tracked in that cycle whose line matches `releasePaddr`. An entry allocated after the release is not marked.
- R7: `revoke` asserted in the cycle right after an accepted, allocating request frees that request's entry. `revoke` asserted at any other time has no effect.
- R8: `retireValid` frees every entry whose age is not younger than `retireAge`. `flushValid` frees every entry.
- R9: When every entry is occupied, `reqReady` is 0 and requests are refused until an entry is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Query request valid |
| reqReady | output | 1 | Query request accepted |
| reqAge | input | AGE_IDX_W+1 | Age tag of the querying load (wrap flag in the top bit) |
| reqPaddr | input | PADDR_W | Physical address of the querying load |
| reqMask | input | MASK_W | Byte mask of the querying load |
| reqDataValid | input | 1 | Querying load has obtained its data |
| respValid | output | 1 | Response valid, one cycle after acceptance |
| respReplay | output | 1 | Restart from fetch required |
| revoke | input | 1 | Cancel the entry allocated by the previous cycle's request |
| releaseValid | input | 1 | A cache line is being released |
| releasePaddr | input | PADDR_W | Address inside the released line |
| retireValid | input | 1 | Free entries not younger than retireAge |
| retireAge | input | AGE_IDX_W+1 | Retire boundary age tag |
| flushValid | input | 1 | Free all entries |

## Verification
The bench builds the block with four entries, 3-bit age indices plus a wrap flag, and 12-bit addresses. With these values all 256 pairs of tracked age and query age can be swept, including the ones that cross the wrap boundary. Filling the table takes only four allocations, so the full-table refusal is easy to reach. Two 64-byte lines inside the 12-bit space are enough to test matching line offsets, different lines, releases that come before allocation, revokes, retires and flushes, each on its own.

// File: rtl/lldChecker_pkg.sv
package lldChecker_pkg;

  // Strobes from control to datapath, one per table action in a cycle.
  typedef struct packed {
    logic queryEn;    // request accepted this cycle
    logic allocEn;    // accepted request allocates an entry
    logic revokeEn;   // previous allocation is cancelled
    logic retireEn;   // age-bounded free
    logic flushEn;    // free everything
    logic releaseEn;  // line release marks entries
  } lldStrobe_t;

endpackage

// File: rtl/lldChecker_ctrl.sv
module lldChecker_ctrl
  import lldChecker_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int MASK_W      = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqDataValid,
  input  logic [MASK_W-1:0]      reqMask,
  input  logic                   revoke,
  input  logic                   releaseValid,
  input  logic                   retireValid,
  input  logic                   flushValid,
  input  logic [NUM_ENTRIES-1:0] entryValid,
  output logic                   reqReady,
  output logic                   respValid,
  output lldStrobe_t             strobe,
  output logic [NUM_ENTRIES-1:0] allocOh,
  output logic [NUM_ENTRIES-1:0] revokeOh
);

  logic [NUM_ENTRIES-1:0] freeVec;
  logic [NUM_ENTRIES-1:0] lowestFree;
  logic [NUM_ENTRIES-1:0] lastAllocOh;
  logic                   tableFull;
  logic                   accepted;
  logic                   hasData;

  assign freeVec    = ~entryValid;
  assign lowestFree = freeVec & (~freeVec + {{(NUM_ENTRIES-1){1'b0}}, 1'b1});
  assign tableFull  = &entryValid;
  assign reqReady   = !releaseValid && !tableFull;
  assign accepted   = reqValid && reqReady;
  assign hasData    = reqDataValid && (|reqMask);

  always_comb begin
    strobe           = '0;
    strobe.queryEn   = accepted;
    strobe.allocEn   = accepted && hasData;
    strobe.revokeEn  = revoke && (|lastAllocOh);
    strobe.retireEn  = retireValid;
    strobe.flushEn   = flushValid;
    strobe.releaseEn = releaseValid;
  end

  assign allocOh  = strobe.allocEn ? lowestFree : '0;
  assign revokeOh = revoke ? lastAllocOh : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAllocOh <= '0;
      respValid   <= 1'b0;
    end else begin
      lastAllocOh <= flushValid ? '0 : allocOh;
      respValid   <= accepted;
    end
  end

endmodule

// File: rtl/lldChecker_dp.sv
module lldChecker_dp
  import lldChecker_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int AGE_IDX_W   = 5,
  parameter int PADDR_W     = 36,
  parameter int LINE_OFF_W  = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lldStrobe_t             strobe,
  input  logic [NUM_ENTRIES-1:0] allocOh,
  input  logic [NUM_ENTRIES-1:0] revokeOh,
  input  logic [AGE_IDX_W:0]     reqAge,
  input  logic [PADDR_W-1:0]     reqPaddr,
  input  logic [PADDR_W-1:0]     releasePaddr,
  input  logic [AGE_IDX_W:0]     retireAge,
  output logic [NUM_ENTRIES-1:0] entryValid,
  output logic                   respReplay
);

  localparam int AGE_W  = AGE_IDX_W + 1;
  localparam int LINE_W = PADDR_W - LINE_OFF_W;

  logic [LINE_W-1:0]     reqLine;
  logic [LINE_W-1:0]     relLine;
  logic [NUM_ENTRIES-1:0] hitVec;
  logic                  unusedOffsets;

  assign reqLine       = reqPaddr[PADDR_W-1:LINE_OFF_W];
  assign relLine       = releasePaddr[PADDR_W-1:LINE_OFF_W];
  assign unusedOffsets = ^{reqPaddr[LINE_OFF_W-1:0], releasePaddr[LINE_OFF_W-1:0]};

  // Wrap-flag age ordering: is tag a younger than tag b?
  function automatic logic isYounger(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    if (a[AGE_W-1] == b[AGE_W-1]) return a[AGE_W-2:0] > b[AGE_W-2:0];
    else return a[AGE_W-2:0] < b[AGE_W-2:0];
  endfunction

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    logic              valid;
    logic              released;
    logic [AGE_W-1:0]  age;
    logic [LINE_W-1:0] line;
    logic              retireHit;

    assign retireHit = strobe.retireEn && valid && !isYounger(age, retireAge);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        valid    <= 1'b0;
        released <= 1'b0;
        age      <= '0;
        line     <= '0;
      end else if (strobe.flushEn) begin
        valid    <= 1'b0;
        released <= 1'b0;
      end else if (revokeOh[i] || retireHit) begin
        valid    <= 1'b0;
        released <= 1'b0;
      end else if (allocOh[i]) begin
        valid    <= 1'b1;
        released <= 1'b0;
        age      <= reqAge;
        line     <= reqLine;
      end else if (strobe.releaseEn && valid && (line == relLine)) begin
        released <= 1'b1;
      end
    end

    assign entryValid[i] = valid;
    assign hitVec[i]     = valid && released && (line == reqLine) && isYounger(age, reqAge);
  end

  always_ff @(posedge clk) begin
    if (!rstN) respReplay <= 1'b0;
    else       respReplay <= strobe.queryEn && (|hitVec);
  end

endmodule

// File: rtl/lldChecker.sv
module lldChecker
  import lldChecker_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int AGE_IDX_W   = 5,
  parameter int PADDR_W     = 36,
  parameter int MASK_W      = 16,
  parameter int LINE_OFF_W  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [AGE_IDX_W:0]   reqAge,
  input  logic [PADDR_W-1:0]   reqPaddr,
  input  logic [MASK_W-1:0]    reqMask,
  input  logic                 reqDataValid,
  output logic                 respValid,
  output logic                 respReplay,
  input  logic                 revoke,
  input  logic                 releaseValid,
  input  logic [PADDR_W-1:0]   releasePaddr,
  input  logic                 retireValid,
  input  logic [AGE_IDX_W:0]   retireAge,
  input  logic                 flushValid
);

  lldStrobe_t             strobe;
  logic [NUM_ENTRIES-1:0] allocOh;
  logic [NUM_ENTRIES-1:0] revokeOh;
  logic [NUM_ENTRIES-1:0] entryValid;

  lldChecker_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .MASK_W(MASK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDataValid(reqDataValid),
    .reqMask(reqMask), .revoke(revoke), .releaseValid(releaseValid),
    .retireValid(retireValid), .flushValid(flushValid), .entryValid(entryValid),
    .reqReady(reqReady), .respValid(respValid), .strobe(strobe),
    .allocOh(allocOh), .revokeOh(revokeOh)
  );

  lldChecker_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .AGE_IDX_W(AGE_IDX_W),
    .PADDR_W(PADDR_W), .LINE_OFF_W(LINE_OFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocOh(allocOh), .revokeOh(revokeOh),
    .reqAge(reqAge), .reqPaddr(reqPaddr), .releasePaddr(releasePaddr),
    .retireAge(retireAge), .entryValid(entryValid), .respReplay(respReplay)
  );

endmodule

// File: rtl/lldChecker_sva.sv
module lldChecker_sva #(
  parameter int NUM_ENTRIES = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqReady,
  input logic                   respValid,
  input logic                   respReplay,
  input logic                   releaseValid,
  input logic                   flushValid,
  input logic [NUM_ENTRIES-1:0] entryValid
);

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> respValid); // R2

  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !respValid); // R2

  AST_REPLAY_WITH_RESP: assert property (@(posedge clk) disable iff (!rstN)
    respReplay |-> respValid); // R3

  AST_REFUSE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    releaseValid |-> !reqReady); // R1

  AST_REFUSE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (&entryValid) |-> !reqReady); // R9

  AST_SINGLE_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    $countones(entryValid) <= $past($countones(entryValid)) + 1); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (entryValid == '0)); // R8

endmodule

bind lldChecker lldChecker_sva #(.NUM_ENTRIES(NUM_ENTRIES)) u_sva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respReplay(respReplay), .releaseValid(releaseValid),
  .flushValid(flushValid), .entryValid(entryValid)
);

// File: tb/lldChecker_bench.sv
module lldChecker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int AIW = 3;
  localparam int PW = 12;
  localparam int MW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqDataValid = 1'b0, revoke = 1'b0;
  logic releaseValid = 1'b0, retireValid = 1'b0, flushValid = 1'b0;
  logic [AIW:0] reqAge = '0, retireAge = '0;
  logic [PW-1:0] reqPaddr = '0, releasePaddr = '0;
  logic [MW-1:0] reqMask = '0;
  logic reqReady, respValid, respReplay;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lldChecker #(.NUM_ENTRIES(NE), .AGE_IDX_W(AIW), .PADDR_W(PW), .MASK_W(MW), .LINE_OFF_W(6)) u_lldChecker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAge(reqAge),
    .reqPaddr(reqPaddr), .reqMask(reqMask), .reqDataValid(reqDataValid),
    .respValid(respValid), .respReplay(respReplay), .revoke(revoke),
    .releaseValid(releaseValid), .releasePaddr(releasePaddr),
    .retireValid(retireValid), .retireAge(retireAge), .flushValid(flushValid)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Sends one request; returns at the negedge where the response is visible.
  task automatic doReq(input logic [AIW:0] age, input logic [PW-1:0] pa,
                       input logic [MW-1:0] m, input logic dv);
    reqValid = 1'b1; reqAge = age; reqPaddr = pa; reqMask = m; reqDataValid = dv;
    @(negedge clk);
    reqValid = 1'b0; reqDataValid = 1'b0;
  endtask

  task automatic doRelease(input logic [PW-1:0] pa);
    releaseValid = 1'b1; releasePaddr = pa;
    @(negedge clk);
    releaseValid = 1'b0;
  endtask

  task automatic doFlush();
    flushValid = 1'b1;
    @(negedge clk);
    flushValid = 1'b0;
  endtask

  task automatic doRetire(input logic [AIW:0] age);
    retireValid = 1'b1; retireAge = age;
    @(negedge clk);
    retireValid = 1'b0;
  endtask

  // Query from age 0 on line 1; result of the R3 rule.
  task automatic probe(input string tag, input logic exp);
    doReq(4'd0, 12'h048, 16'h00FF, 1'b0);
    check(tag, respReplay, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset ready", reqReady, 1'b1);
    check("R2 reset respValid", respValid, 1'b0);
    @(negedge clk);

    // R3/R4 sweep over every tracked/query age pair, including wrap crossings.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int d;
        logic exp;
        d = (a - b) & 15;
        exp = (d >= 1) && (d <= 7);
        doFlush();
        doReq(a[AIW:0], 12'h040, 16'h0001, 1'b1);
        doRelease(12'h07F);
        doReq(b[AIW:0], 12'h050, 16'h000F, 1'b0);
        check("R2 resp after accept", respValid, 1'b1);
        check($sformatf("R4 age a=%0d b=%0d", a, b), respReplay, exp);
      end
    end

    // R3 no release: no replay
    doFlush(); doReq(4'd5, 12'h040, 16'h1, 1'b1);
    probe("R3 unreleased entry", 1'b0);
    // R3 release of another line does not mark
    doFlush(); doReq(4'd5, 12'h040, 16'h1, 1'b1); doRelease(12'h080);
    probe("R3 other line released", 1'b0);
    // R3 query to another line
    doFlush(); doReq(4'd5, 12'h040, 16'h1, 1'b1); doRelease(12'h040);
    doReq(4'd0, 12'h0C0, 16'h1, 1'b0);
    check("R3 query other line", respReplay, 1'b0);
    // R5 dataValid low: no allocation
    doFlush(); doReq(4'd5, 12'h040, 16'h1, 1'b0); doRelease(12'h040);
    probe("R5 no data no alloc", 1'b0);
    // R5 zero mask: no allocation
    doFlush(); doReq(4'd5, 12'h040, 16'h0, 1'b1); doRelease(12'h040);
    probe("R5 zero mask no alloc", 1'b0);
    // R6 release before allocation does not mark
    doFlush(); doRelease(12'h040); doReq(4'd5, 12'h040, 16'h1, 1'b1);
    probe("R6 release before alloc", 1'b0);

    // R7 revoke right after allocation frees the entry
    doFlush();
    reqValid = 1'b1; reqAge = 4'd5; reqPaddr = 12'h040; reqMask = 16'h1; reqDataValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; reqDataValid = 1'b0; revoke = 1'b1;
    check("R2 resp during revoke cycle", respValid, 1'b1);
    @(negedge clk);
    revoke = 1'b0;
    doRelease(12'h040);
    probe("R7 revoked entry gone", 1'b0);
    // R7 late revoke has no effect
    doFlush(); doReq(4'd5, 12'h040, 16'h1, 1'b1); @(negedge clk);
    revoke = 1'b1; @(negedge clk); revoke = 1'b0;
    doRelease(12'h040);
    probe("R7 late revoke ignored", 1'b1);

    // R8 retire frees old entries, keeps younger
    doFlush(); doReq(4'd2, 12'h040, 16'h1, 1'b1); doReq(4'd5, 12'h040, 16'h1, 1'b1);
    doRelease(12'h040); doRetire(4'd3);
    probe("R8 retire keeps younger", 1'b1);
    doRetire(4'd5);
    probe("R8 retire frees equal age", 1'b0);
    // R8 flush frees all
    doFlush(); doReq(4'd5, 12'h040, 16'h1, 1'b1); doRelease(12'h040); doFlush();
    probe("R8 flush frees all", 1'b0);

    // R9 full table refuses
    doFlush();
    for (int k = 1; k <= 4; k++) doReq(k[AIW:0], 12'h040, 16'h1, 1'b1);
    #1;
    check("R9 full not ready", reqReady, 1'b0);
    doReq(4'd0, 12'h040, 16'h1, 1'b0);
    check("R2 no resp when refused", respValid, 1'b0);
    doFlush(); #1;
    check("R9 ready after flush", reqReady, 1'b1);

    // R1 release refuses request
    @(negedge clk);
    releaseValid = 1'b1; releasePaddr = 12'h100; reqValid = 1'b1; reqAge = 4'd0;
    reqDataValid = 1'b0; #1;
    check("R1 not ready during release", reqReady, 1'b0);
    @(negedge clk);
    releaseValid = 1'b0; reqValid = 1'b0;
    check("R1 refused gives no resp", respValid, 1'b0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule